// File: doc/BRIEF.md
# Host-Fed Monochrome Colour Expander

This block turns a one-bit-per-pixel bitmap, typically a font glyph, into a rectangle of 8-bit pixels in a byte-addressed framebuffer. Software first programs a destination start address, a destination pitch, the two colours and the rectangle size. Writing the size arms the engine. The host then pushes the bitmap through a 32-bit data port. Each source bit becomes one destination byte: the foreground colour where the bit is set and the background colour where it is clear. The byte for pixel (x, y) of the rectangle lands at start + x + y × pitch.

The controller has four states. `ST_IDLE` accepts and discards data-port words and accepts register writes. A valid size write (arm) moves it to `ST_FETCH`. `ST_FETCH` holds the data port ready and, once it takes a word, moves to `ST_PAINT`. `ST_PAINT` issues one memory byte write per source bit and advances on each acknowledge. When it uses up a word with pixels still left, it returns to `ST_FETCH`. After the last pixel it goes to `ST_IDLE` if an even number of words arrived, and to `ST_PAD` if the count was odd. `ST_PAD` waits for one filler word, discards it, and returns to `ST_IDLE`. Busy is high in every state except `ST_IDLE`.

Top module: `glyph_expander`

## Requirements
- R1: After reset, busy is 0, mem_req is 0 and dp_ready is 1.
- R2: A register write to address 2 (size) while idle arms the engine, and busy is 1 from the next cycle. If the written height (bits 31:16) or width (bits 15:0) is zero, the engine does not arm and busy stays 0.
- R3: A data word holds four bitmap bytes, consumed in this order: bits 7:0 first, then 15:8, then 23:16, then 31:24. Within a byte, bit 7 is the leftmost pixel.
- R4: A set source bit writes the low byte of the foreground register (address 3). A clear bit writes the low byte of the background register (address 4).
- R5: Pixel (x, y) is written at dest + x + y × pitch. The destination start comes from register address 0. The pitch comes from bits 31:16 of register address 1, and bits 15:0 of that register are ignored. Pixels are written in raster order.
- R6: Every scanline starts on a new source byte. The unused low-order bits of a row's last byte are discarded.
- R7: While a byte write is pending, dp_ready is 0, and mem_addr and mem_data hold steady until mem_ack. Each acknowledge retires exactly one pixel.
- R8: If an odd number of words carried the bitmap, busy stays 1 after the last pixel until one more data word is accepted. If the number was even, busy falls in the cycle after the last acknowledge.
- R9: Data words offered while the engine is idle are accepted and discarded. This includes a word offered in the same cycle as the arming size write. None of these words contributes to the next rectangle.
- R10: Register writes made while busy are ignored. A colour change does not affect the pixels of the running operation, and a size write does not re-arm it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 dest, 1 stride, 2 size, 3 fg, 4 bg |
| reg_wdata | input | 32 | Register write data |
| dp_valid | input | 1 | Data-port word valid |
| dp_data | input | 32 | Data-port bitmap word |
| dp_ready | output | 1 | Data port can take a word |
| mem_req | output | 1 | Byte write request |
| mem_addr | output | AW | Byte write address |
| mem_data | output | 8 | Byte write data |
| mem_ack | input | 1 | Byte write accepted this cycle |
| busy | output | 1 | Operation in progress |

## Verification
Two pairs of functions can meet in one cycle. The first pair is the arming size write and a data-port word. The bench drives both in the same cycle and judges the result at the memory port: every pixel of the operation must come from the words sent afterwards, never from the all-ones word that collided with the arm. The second pair is a colour or size register write and an ongoing expansion. The bench issues these writes after the first word has been taken and checks that the remaining pixels keep the original colours and that the pixel count is unchanged. A sweep over widths 1 to 17, several heights and two acknowledge patterns compares every byte write against arithmetically computed address and colour.

// File: rtl/glx_pkg.sv
package glx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_PAINT = 2'd2,
        ST_PAD   = 2'd3
    } glx_state_e;

    localparam logic [2:0] REG_DEST   = 3'd0;
    localparam logic [2:0] REG_STRIDE = 3'd1;
    localparam logic [2:0] REG_SIZE   = 3'd2;
    localparam logic [2:0] REG_FG     = 3'd3;
    localparam logic [2:0] REG_BG     = 3'd4;

    localparam int FIELD_W = 16;
    localparam int PIX_W   = 8;
    localparam int WORD_W  = 32;

endpackage

// File: rtl/glx_cfg.sv
module glx_cfg
    import glx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    input  logic                 busy,
    output logic [AW-1:0]        dest_q,
    output logic [FIELD_W-1:0]   pitch_q,
    output logic [FIELD_W-1:0]   width_q,
    output logic [FIELD_W-1:0]   height_q,
    output logic [PIX_W-1:0]     fg_q,
    output logic [PIX_W-1:0]     bg_q,
    output logic                 arm
);

    logic accept;
    logic unused_bits;

    assign accept      = reg_we && !busy;
    assign unused_bits = ^reg_wdata;
    assign arm = accept && (reg_addr == REG_SIZE)
                 && (reg_wdata[31:16] != '0) && (reg_wdata[15:0] != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q   <= '0;
            pitch_q  <= '0;
            width_q  <= '0;
            height_q <= '0;
            fg_q     <= '0;
            bg_q     <= '0;
        end else if (accept) begin
            unique case (reg_addr)
                REG_DEST:   dest_q   <= reg_wdata[AW-1:0];
                REG_STRIDE: pitch_q  <= reg_wdata[31:16];
                REG_SIZE: begin
                    height_q <= reg_wdata[31:16];
                    width_q  <= reg_wdata[15:0];
                end
                REG_FG:     fg_q     <= reg_wdata[PIX_W-1:0];
                REG_BG:     bg_q     <= reg_wdata[PIX_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/glx_cursor.sv
module glx_cursor
    import glx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    input  logic [AW-1:0]        dest,
    input  logic [FIELD_W-1:0]   pitch,
    input  logic [FIELD_W-1:0]   width,
    input  logic [FIELD_W-1:0]   height,
    output logic [AW-1:0]        addr,
    output logic [4:0]           bit_sel,
    output logic                 last_pix,
    output logic                 word_end
);

    logic [FIELD_W-1:0] x_q, y_q;
    logic [2:0]         bit_q;
    logic [1:0]         byte_q;
    logic [AW-1:0]      row_base_q;
    logic               row_end;
    logic               next_byte;

    assign row_end   = (x_q == FIELD_W'(width - 16'd1));
    assign last_pix  = row_end && (y_q == FIELD_W'(height - 16'd1));
    assign next_byte = row_end || (bit_q == 3'd0);
    assign word_end  = next_byte && (byte_q == 2'd3);
    assign bit_sel   = {byte_q, bit_q};
    assign addr      = row_base_q + AW'(x_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q        <= '0;
            y_q        <= '0;
            bit_q      <= 3'd7;
            byte_q     <= '0;
            row_base_q <= '0;
        end else if (load) begin
            x_q        <= '0;
            y_q        <= '0;
            bit_q      <= 3'd7;
            byte_q     <= '0;
            row_base_q <= dest;
        end else if (step) begin
            if (row_end) begin
                x_q        <= '0;
                y_q        <= FIELD_W'(y_q + 16'd1);
                row_base_q <= row_base_q + AW'(pitch);
            end else begin
                x_q <= FIELD_W'(x_q + 16'd1);
            end
            if (next_byte) begin
                bit_q  <= 3'd7;
                byte_q <= byte_q + 2'd1;
            end else begin
                bit_q <= bit_q - 3'd1;
            end
        end
    end

endmodule

// File: rtl/glyph_expander.sv
module glyph_expander
    import glx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              dp_valid,
    input  logic [31:0]       dp_data,
    output logic              dp_ready,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    output logic [7:0]        mem_data,
    input  logic              mem_ack,
    output logic              busy
);

    glx_state_e          state_q, state_nx;
    logic [WORD_W-1:0]   word_q;
    logic                odd_q;

    logic [AW-1:0]       dest_q;
    logic [FIELD_W-1:0]  pitch_q, width_q, height_q;
    logic [PIX_W-1:0]    fg_q, bg_q;
    logic                arm;
    logic                step;
    logic [4:0]          bit_sel;
    logic                last_pix, word_end;
    logic                take_word;

    glx_cfg #(.AW(AW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .busy     (busy),
        .dest_q   (dest_q),
        .pitch_q  (pitch_q),
        .width_q  (width_q),
        .height_q (height_q),
        .fg_q     (fg_q),
        .bg_q     (bg_q),
        .arm      (arm)
    );

    glx_cursor #(.AW(AW)) u_cursor (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (arm),
        .step    (step),
        .dest    (dest_q),
        .pitch   (pitch_q),
        .width   (width_q),
        .height  (height_q),
        .addr    (mem_addr),
        .bit_sel (bit_sel),
        .last_pix(last_pix),
        .word_end(word_end)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (arm) state_nx = ST_FETCH;
            ST_FETCH: if (dp_valid) state_nx = ST_PAINT;
            ST_PAINT: begin
                if (mem_ack) begin
                    if (last_pix)      state_nx = odd_q ? ST_PAD : ST_IDLE;
                    else if (word_end) state_nx = ST_FETCH;
                end
            end
            ST_PAD:   if (dp_valid) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        dp_ready = 1'b0;
        mem_req  = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                dp_ready = 1'b1;
                busy     = 1'b0;
            end
            ST_FETCH: dp_ready = 1'b1;
            ST_PAINT: mem_req  = 1'b1;
            ST_PAD:   dp_ready = 1'b1;
            default:  busy     = 1'b0;
        endcase
    end

    assign take_word = (state_q == ST_FETCH) && dp_valid;
    assign step      = (state_q == ST_PAINT) && mem_ack;
    assign mem_data  = word_q[bit_sel] ? fg_q : bg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            odd_q  <= 1'b0;
        end else if (arm) begin
            odd_q  <= 1'b0;
        end else if (take_word) begin
            word_q <= dp_data;
            odd_q  <= ~odd_q;
        end
    end

endmodule

// File: rtl/glx_check.sv
module glx_check #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [2:0]    reg_addr,
    input logic          dp_ready,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_data,
    input logic          mem_ack,
    input logic          busy,
    input logic [7:0]    fg_q,
    input logic [7:0]    bg_q
);

    p_no_ready_while_painting_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !dp_ready);

    p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));

    p_idle_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    p_colour_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_data == fg_q || mem_data == bg_q));

    p_arm_by_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_we && reg_addr == 3'd2));

endmodule

bind glyph_expander glx_check #(.AW(AW)) u_glx_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_we  (reg_we),
    .reg_addr(reg_addr),
    .dp_ready(dp_ready),
    .mem_req (mem_req),
    .mem_addr(mem_addr),
    .mem_data(mem_data),
    .mem_ack (mem_ack),
    .busy    (busy),
    .fg_q    (fg_q),
    .bg_q    (bg_q)
);

// File: tb/glyph_expander_test.sv
module glyph_expander_test;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          dp_valid = 1'b0;
    logic [31:0]   dp_data = '0;
    logic          dp_ready;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data;
    logic          mem_ack = 1'b0;
    logic          busy;

    int errors = 0;
    int checks = 0;
    int done_cnt = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    glyph_expander #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .dp_valid(dp_valid), .dp_data(dp_data),
        .dp_ready(dp_ready), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_ack(mem_ack), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] src_byte(input int seed, input int idx);
        if (seed == 0) return 8'hFF;
        if (seed == 1) return 8'h00;
        return 8'((idx * 73 + seed * 29 + (idx >> 2) * 5) ^ (seed * 3));
    endfunction

    function automatic logic [31:0] src_word(input int seed, input int j);
        return {src_byte(seed, 4*j+3), src_byte(seed, 4*j+2),
                src_byte(seed, 4*j+1), src_byte(seed, 4*j)};
    endfunction

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // called at a negedge; returns at the negedge after the accepting edge
    task automatic push(input logic [31:0] w);
        bit r;
        dp_valid = 1'b1; dp_data = w;
        forever begin
            r = dp_ready;
            @(posedge clk);
            @(negedge clk);
            if (r) break;
        end
        dp_valid = 1'b0;
    endtask

    task automatic run_op(input int dest, input int pitch, input int w, input int h,
                          input int seed, input int fg, input int bg,
                          input int ackmode, input bit collide, input bit midwrite);
        int bpr, nwords, total;
        bpr    = (w + 7) / 8;
        nwords = (bpr * h + 3) / 4;
        total  = w * h;
        done_cnt = 0;
        wr_reg(3'd0, 32'(dest));
        wr_reg(3'd1, {16'(pitch), 16'hBEEF});
        wr_reg(3'd3, 32'(fg));
        wr_reg(3'd4, 32'(bg));
        if (collide) begin
            dp_valid = 1'b1; dp_data = 32'hFFFF_FFFF;
        end
        wr_reg(3'd2, {16'(h), 16'(w)});
        dp_valid = 1'b0;
        check(busy == 1'b1, "R2 arm", int'(busy), 1);
        fork
            begin : feeder
                for (int j = 0; j < nwords; j++) begin
                    push(src_word(seed, j));
                    if (midwrite && j == 0) begin
                        wr_reg(3'd3, 32'(~fg));
                        wr_reg(3'd4, 32'(~bg));
                        wr_reg(3'd2, 32'h0001_0001);
                    end
                end
                wait (done_cnt == total);
                if (nwords % 2 == 1) begin
                    repeat (3) @(negedge clk);
                    check(busy == 1'b1, "R8 pad pending", int'(busy), 1);
                    push(32'h0);
                    check(busy == 1'b0, "R8 pad taken", int'(busy), 0);
                end else begin
                    @(negedge clk);
                    check(busy == 1'b0, "R8 even done", int'(busy), 0);
                end
            end
            begin : monitor
                bit tog = 1'b0;
                while (done_cnt < total) begin
                    @(negedge clk);
                    if (mem_req) begin
                        check(dp_ready == 1'b0, "R7 ready low", int'(dp_ready), 0);
                        tog = ~tog;
                        if (ackmode == 0 || tog) begin
                            int x, y, bi, ea;
                            logic [7:0] sb, ed;
                            mem_ack = 1'b1;
                            x  = done_cnt % w;
                            y  = done_cnt / w;
                            bi = y * bpr + x / 8;
                            sb = src_byte(seed, bi);
                            ed = sb[7 - (x % 8)] ? 8'(fg) : 8'(bg);
                            ea = (dest + x + y * pitch) % (1 << AW);
                            check(int'(mem_addr) == ea, "R5 address", int'(mem_addr), ea);
                            check(mem_data == ed, "R3 R4 R6 R10 pixel", int'(mem_data), int'(ed));
                            done_cnt++;
                        end else begin
                            mem_ack = 1'b0;
                        end
                    end else begin
                        mem_ack = 1'b0;
                    end
                end
                @(negedge clk);
                mem_ack = 1'b0;
            end
        join
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(mem_req == 1'b0, "R1 mem_req", int'(mem_req), 0);
        check(dp_ready == 1'b1, "R1 dp_ready", int'(dp_ready), 1);

        // R2 zero sizes do not arm
        wr_reg(3'd2, 32'h0000_0005);
        check(busy == 1'b0, "R2 zero height", int'(busy), 0);
        wr_reg(3'd2, 32'h0003_0000);
        check(busy == 1'b0, "R2 zero width", int'(busy), 0);

        // R9 idle words dropped: all-ones word, then all-zero bitmap -> background only
        push(32'hFFFF_FFFF);
        check(busy == 1'b0, "R9 idle word", int'(busy), 0);
        run_op(100, 40, 8, 2, 1, 8'hA5, 8'h3C, 0, 1'b0, 1'b0);

        // R9 collision of arm and data word
        run_op(7, 16, 10, 2, 1, 8'h11, 8'h22, 1, 1'b1, 1'b0);

        // R3 byte order check: 32 pixels, one row, mixed bitmap
        run_op(0, 64, 32, 1, 5, 8'hF0, 8'h0F, 0, 1'b0, 1'b0);

        // R10 register writes while busy
        run_op(300, 20, 12, 3, 9, 8'h5A, 8'hC3, 1, 1'b0, 1'b1);

        // R4 R5 R6 R8 sweep over small shapes
        for (int w = 1; w <= 17; w++) begin
            for (int h = 1; h <= 3; h++) begin
                run_op(w * 37 + h, 24 + h, w, h, 2 + w + h * 7, 8'hE0 + w, 8'h10 + h,
                       (w + h) % 2, 1'b0, 1'b0);
            end
        end

        // R5 address wrap with a wide pitch
        run_op(65500, 1000, 9, 3, 4, 8'h81, 8'h18, 0, 1'b0, 1'b0);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule